// File: doc/BRIEF.md
# Ten-gigabit receive frame extractor

This block sits behind a 64-bit, two-column parallel receive interface. Each clock it takes eight byte lanes and one control flag per lane. Lanes 0 to 3 hold the earlier column and lanes 4 to 7 the later one. The block hunts for a start word that opens a frame. It forwards the payload bytes that follow to a client interface, which carries the 64-bit data and a per-byte valid mask. It drops the four check bytes at the tail and judges the frame from them, from the closing control character and from the frame length.

A frame may only begin in byte 0 of a word, so the payload is always lane-aligned and no byte shifting is needed. The check bytes can straddle two words. For that reason the output stage looks one word ahead before it releases a word. After the last payload word, a one-cycle good or bad pulse gives the verdict. The client needs no side information to find frame boundaries: the mask is zero outside payload, and the pulse marks the end.

Top module: `xgrx_frame_rx`

## Requirements
- R1: While rst_ni is low, rx_valid_o is zero, rx_data_o is zero and neither rx_good_o nor rx_bad_o is high.
- R2: A frame opens only on the word 0xD5555555_555555FB with control mask 0x01 (start 0xFB in byte 0, 0x55 in bytes 1 to 6, delimiter 0xD5 in byte 7). Idle words (0x07 in all lanes, all control bits set), the start word itself and anything outside a frame give a zero valid mask.
- R3: A start character in any lane other than byte 0 (for example byte 4 with control mask 0x1F) is ignored. The words after it give no valid bytes and no status pulse until a proper start word arrives.
- R4: Payload byte i of a frame appears in lane i mod 8 of rx_data_o. A word presented at clock edge n is on rx_data_o after edge n+1.
- R5: The four bytes just before the closing control character are never marked valid, and every payload byte is. This holds for every position 0 to 7 of the closing character, including the case where the check bytes span two words. The valid mask is always contiguous from lane 0.
- R6: The check value is a CRC-32 over the payload: polynomial 0x04C11DB7, bit-reflected, seeded with all ones, inverted at the end, and sent least significant byte first. A frame with a correct check value, closed by 0xFD and at least 64 data bytes long including the check bytes, is flagged good.
- R7: A frame whose check bytes do not match is flagged bad.
- R8: A frame closed by 0xFE is flagged bad and never good.
- R9: Any other control character inside a frame (for example 0x9C) ends the frame and flags it bad. The block then hunts for the next start word.
- R10: A frame with fewer than MIN_BYTES (64) data bytes, counting the check bytes, is flagged bad.
- R11: Per frame, exactly one of rx_good_o or rx_bad_o pulses for one cycle. The pulse comes in the cycle right after the output word that carries the last payload byte, with a zero valid mask, and never together with the other flag.
- R12: A start word right after the closing word, with no idle between frames, is accepted. Both frames are delivered and flagged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| xd_i | input | 8*LANES | Receive data, byte lane l at bits 8l+7:8l |
| xc_i | input | LANES | Per-lane control flags |
| rx_data_o | output | 8*LANES | Client data |
| rx_valid_o | output | LANES | Per-byte payload valid mask |
| rx_good_o | output | 1 | One-cycle pulse: frame accepted |
| rx_bad_o | output | 1 | One-cycle pulse: frame rejected |

## Verification
Data and mask for an input word are due two clock edges after it is presented. The status pulse is due one output cycle after the word holding the last payload byte. That is the same output slot as the closing word when the closing character sits in lanes 0 to 4, and one slot later otherwise. The bench model computes, from the byte stream alone, an expected mask, data, good and bad value for every output slot. It samples on the falling edge and compares slot k two iterations after it drove word k, so every stimulus meets its result exactly at the cycle where it is due. Frames sized 60 to 67 sweep every position of the closing character.

// File: rtl/xgrx_pkg.sv
package xgrx_pkg;
  localparam logic [7:0] XG_IDLE  = 8'h07;
  localparam logic [7:0] XG_START = 8'hFB;
  localparam logic [7:0] XG_TERM  = 8'hFD;
  localparam logic [7:0] XG_ERR   = 8'hFE;
  localparam logic [7:0] XG_PRE   = 8'h55;
  localparam logic [7:0] XG_SFD   = 8'hD5;

  localparam int FCS_BYTES = 4;
  localparam logic [31:0] CRC_REFL_POLY = 32'hEDB88320;
  localparam logic [31:0] CRC_SEED      = 32'hFFFFFFFF;
  localparam logic [31:0] CRC_GOOD_RES  = 32'hDEBB20E3;

  typedef enum logic {ST_HUNT, ST_BODY} rx_state_e;

  function automatic logic [31:0] crc_upd8(input logic [31:0] c, input logic [7:0] b);
    logic [31:0] r;
    r = c;
    for (int k = 0; k < 8; k++) r = (r >> 1) ^ (CRC_REFL_POLY & {32{r[0] ^ b[k]}});
    return r;
  endfunction
endpackage

// File: rtl/xgrx_ctl_scan.sv
module xgrx_ctl_scan #(
  parameter int LANES = 8,
  parameter int LW    = $clog2(LANES + 1)
) (
  input  logic [8*LANES-1:0] d_i,
  input  logic [LANES-1:0]   c_i,
  output logic [LW-1:0]      pos_o,
  output logic [7:0]         code_o
);
  // lowest lane with a control flag; LANES when none
  always_comb begin
    pos_o  = LW'(LANES);
    code_o = 8'h00;
    for (int l = LANES - 1; l >= 0; l--) begin
      if (c_i[l]) begin
        pos_o  = LW'(l);
        code_o = d_i[8*l +: 8];
      end
    end
  end
endmodule

// File: rtl/xgrx_crc_chain.sv
module xgrx_crc_chain
  import xgrx_pkg::*;
#(
  parameter int LANES = 8,
  parameter int LW    = $clog2(LANES + 1)
) (
  input  logic [31:0]        crc_i,
  input  logic [8*LANES-1:0] d_i,
  input  logic [LW-1:0]      n_i,
  output logic [31:0]        crc_o
);
  logic [31:0] st [LANES+1];

  assign st[0] = crc_i;
  for (genvar g = 0; g < LANES; g++) begin : g_byte
    assign st[g+1] = (n_i > LW'(g)) ? crc_upd8(st[g], d_i[8*g +: 8]) : st[g];
  end
  assign crc_o = st[LANES];
endmodule

// File: rtl/xgrx_frame_fsm.sv
module xgrx_frame_fsm
  import xgrx_pkg::*;
#(
  parameter int LANES     = 8,
  parameter int MIN_BYTES = 64,
  parameter int LW        = $clog2(LANES + 1),
  parameter int CW        = $clog2(MIN_BYTES + 1)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [8*LANES-1:0] d_i,
  input  logic [LANES-1:0]   c_i,
  input  logic [LW-1:0]      end_pos_i,
  input  logic [7:0]         end_code_i,
  output logic [8*LANES-1:0] s1_data_o,
  output logic               s1_pay_o,
  output logic [LW-1:0]      s1_end_o,
  output logic               verdict_o,
  output logic               in_frame_o
);
  rx_state_e          state_q;
  logic [31:0]        crc_q, crc_nxt;
  logic [CW-1:0]      cnt_q, cnt_sat;
  logic [CW:0]        cnt_sum;
  logic [8*LANES-1:0] start_w;
  logic [LANES-1:0]   start_c;
  logic               is_start, frame_end;

  always_comb begin
    start_w = '0;
    for (int l = 0; l < LANES; l++) start_w[8*l +: 8] = XG_PRE;
    start_w[7:0]               = XG_START;
    start_w[8*LANES-1 -: 8]    = XG_SFD;
    start_c                    = '0;
    start_c[0]                 = 1'b1;
  end

  assign is_start   = (c_i == start_c) && (d_i == start_w);
  assign in_frame_o = (state_q == ST_BODY);
  assign frame_end  = in_frame_o && (end_pos_i != LW'(LANES));
  assign cnt_sum    = {1'b0, cnt_q} + (CW+1)'(end_pos_i);
  assign cnt_sat    = (cnt_sum >= (CW+1)'(MIN_BYTES)) ? CW'(MIN_BYTES) : cnt_sum[CW-1:0];

  xgrx_crc_chain #(.LANES(LANES), .LW(LW)) u_crc (
    .crc_i (crc_q),
    .d_i   (d_i),
    .n_i   (end_pos_i),
    .crc_o (crc_nxt)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_HUNT;
      crc_q     <= CRC_SEED;
      cnt_q     <= '0;
      verdict_o <= 1'b0;
      s1_data_o <= '0;
      s1_pay_o  <= 1'b0;
      s1_end_o  <= LW'(LANES);
    end else begin
      s1_data_o <= d_i;
      s1_pay_o  <= in_frame_o;
      s1_end_o  <= in_frame_o ? end_pos_i : LW'(LANES);
      unique case (state_q)
        ST_HUNT: begin
          if (is_start) begin
            state_q <= ST_BODY;
            crc_q   <= CRC_SEED;
            cnt_q   <= '0;
          end
        end
        ST_BODY: begin
          crc_q <= crc_nxt;
          cnt_q <= cnt_sat;
          if (frame_end) begin
            state_q   <= ST_HUNT;
            // residue over payload plus check bytes replaces a byte-steered compare
            verdict_o <= (end_code_i == XG_TERM) && (crc_nxt == CRC_GOOD_RES) &&
                         (cnt_sum >= (CW+1)'(MIN_BYTES));
          end
        end
        default: state_q <= ST_HUNT;
      endcase
    end
  end
endmodule

// File: rtl/xgrx_lane_align.sv
module xgrx_lane_align
  import xgrx_pkg::*;
#(
  parameter int LANES = 8,
  parameter int LW    = $clog2(LANES + 1)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [8*LANES-1:0] s1_data_i,
  input  logic               s1_pay_i,
  input  logic [LW-1:0]      s1_end_i,
  input  logic [LW-1:0]      nxt_end_i,
  input  logic               verdict_i,
  output logic [8*LANES-1:0] data_o,
  output logic [LANES-1:0]   valid_o,
  output logic               good_o,
  output logic               bad_o
);
  localparam logic [LW-1:0] NONE = LW'(LANES);
  localparam logic [LW-1:0] FCS  = LW'(FCS_BYTES);

  logic [LW-1:0]    keep;
  logic [LANES-1:0] mask;
  logic             has_end, flag_now, pend_set, pend_q;

  assign has_end = s1_pay_i && (s1_end_i != NONE);

  // look one word ahead: check bytes may start in the held word
  always_comb begin
    if (!s1_pay_i)      keep = '0;
    else if (has_end)   keep = (s1_end_i >= FCS) ? s1_end_i - FCS : '0;
    else if (nxt_end_i < FCS) keep = LW'(LANES - FCS_BYTES) + nxt_end_i;
    else                keep = NONE;
  end

  for (genvar l = 0; l < LANES; l++) begin : g_mask
    assign mask[l] = keep > LW'(l);
  end

  assign flag_now = has_end && (s1_end_i <= FCS);
  assign pend_set = has_end && (s1_end_i > FCS);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_o  <= '0;
      valid_o <= '0;
      good_o  <= 1'b0;
      bad_o   <= 1'b0;
      pend_q  <= 1'b0;
    end else begin
      data_o  <= s1_data_i;
      valid_o <= mask;
      good_o  <= (flag_now || pend_q) && verdict_i;
      bad_o   <= (flag_now || pend_q) && !verdict_i;
      pend_q  <= pend_set;
    end
  end
endmodule

// File: rtl/xgrx_frame_rx.sv
module xgrx_frame_rx #(
  parameter int LANES     = 8,
  parameter int MIN_BYTES = 64
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [8*LANES-1:0] xd_i,
  input  logic [LANES-1:0]   xc_i,
  output logic [8*LANES-1:0] rx_data_o,
  output logic [LANES-1:0]   rx_valid_o,
  output logic               rx_good_o,
  output logic               rx_bad_o
);
  localparam int LW = $clog2(LANES + 1);
  localparam int CW = $clog2(MIN_BYTES + 1);

  logic [LW-1:0]      end_pos, s1_end;
  logic [7:0]         end_code;
  logic [8*LANES-1:0] s1_data;
  logic               s1_pay, verdict, in_frame;

  xgrx_ctl_scan #(.LANES(LANES), .LW(LW)) u_scan (
    .d_i    (xd_i),
    .c_i    (xc_i),
    .pos_o  (end_pos),
    .code_o (end_code)
  );

  xgrx_frame_fsm #(.LANES(LANES), .MIN_BYTES(MIN_BYTES), .LW(LW), .CW(CW)) u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .d_i        (xd_i),
    .c_i        (xc_i),
    .end_pos_i  (end_pos),
    .end_code_i (end_code),
    .s1_data_o  (s1_data),
    .s1_pay_o   (s1_pay),
    .s1_end_o   (s1_end),
    .verdict_o  (verdict),
    .in_frame_o (in_frame)
  );

  xgrx_lane_align #(.LANES(LANES), .LW(LW)) u_align (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .s1_data_i (s1_data),
    .s1_pay_i  (s1_pay),
    .s1_end_i  (s1_end),
    .nxt_end_i (end_pos),
    .verdict_i (verdict),
    .data_o    (rx_data_o),
    .valid_o   (rx_valid_o),
    .good_o    (rx_good_o),
    .bad_o     (rx_bad_o)
  );
endmodule

// File: rtl/xgrx_frame_rx_chk.sv
module xgrx_frame_rx_chk #(
  parameter int LANES = 8,
  parameter int LW    = $clog2(LANES + 1)
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic [8*LANES-1:0] xd_i,
  input logic [LANES-1:0]   xc_i,
  input logic [8*LANES-1:0] rx_data_o,
  input logic [LANES-1:0]   rx_valid_o,
  input logic               rx_good_o,
  input logic               rx_bad_o,
  input logic [LW-1:0]      end_pos,
  input logic [7:0]         end_code,
  input logic               verdict,
  input logic               in_frame
);
  logic [1:0] age_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) age_q <= '0;
    else if (age_q != 2'd3) age_q <= age_q + 2'd1;
  end

  p_flags_excl_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rx_good_o && rx_bad_o));

  p_flag_pulse_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_good_o || rx_bad_o) |=> !(rx_good_o || rx_bad_o));

  p_flag_no_data_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_good_o || rx_bad_o) |-> (rx_valid_o == '0));

  p_valid_contig_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((rx_valid_o + LANES'(1)) & rx_valid_o) == '0);

  p_abort_bad_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_frame && (end_pos != LW'(LANES)) && (end_code == 8'hFE)) |=> !verdict);

  p_latency_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((age_q >= 2'd2) && (rx_valid_o != '0)) |-> (rx_data_o == $past(xd_i, 2)));

  p_idle_quiet_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((age_q >= 2'd2) && ($past(xc_i, 2) == '1)) |-> (rx_valid_o == '0));
endmodule

bind xgrx_frame_rx xgrx_frame_rx_chk #(.LANES(LANES), .LW(LW)) u_chk (.*);

// File: tb/sim_xgrx_frame_rx.sv
`timescale 1ns/1ps
module sim_xgrx_frame_rx;
  localparam logic [63:0] START_W = 64'hD5555555_555555FB;
  localparam logic [63:0] IDLE_W  = 64'h07070707_07070707;

  logic        clk = 1'b0;
  logic        rst_ni;
  logic [63:0] xd;
  logic [7:0]  xc;
  logic [63:0] rx_data;
  logic [7:0]  rx_valid;
  logic        rx_good, rx_bad;

  always #10 clk = ~clk;

  xgrx_frame_rx u0 (
    .clk_i(clk), .rst_ni(rst_ni), .xd_i(xd), .xc_i(xc),
    .rx_data_o(rx_data), .rx_valid_o(rx_valid), .rx_good_o(rx_good), .rx_bad_o(rx_bad)
  );

  logic [63:0] wd[$];
  logic [7:0]  wc[$];
  string       wt[$];
  logic [7:0]  fb[$];
  int          fp[$];
  logic [7:0]  exp_v[];
  logic [63:0] exp_d[];
  logic        exp_g[], exp_b[];
  string       ft[];
  int nchk = 0, nfail = 0, seed = 7;
  bit done = 0;

  function automatic logic [7:0] rnd8();
    seed = seed * 1103515245 + 12345;
    return seed[23:16];
  endfunction

  function automatic logic [31:0] crc32(logic [7:0] q[$]);
    logic [31:0] c = 32'hFFFFFFFF;
    foreach (q[i])
      for (int j = 0; j < 8; j++)
        c = (c[0] ^ q[i][j]) ? ((c >> 1) ^ 32'hEDB88320) : (c >> 1);
    return ~c;
  endfunction

  task automatic push_word(logic [63:0] d, logic [7:0] c, string t);
    wd.push_back(d); wc.push_back(c); wt.push_back(t);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) push_word(IDLE_W, 8'hFF, "R2");
  endtask

  // mode: 0 good, 1 corrupt check, 2 abort 0xFE, 3 stray control at byte 30
  task automatic add_frame(int n, int mode, string t, int gap);
    logic [7:0] pl[$], sb[$];
    logic       sc[$];
    logic [31:0] fcs;
    push_word(START_W, 8'h01, t);
    for (int i = 0; i < n; i++) pl.push_back(rnd8());
    fcs = crc32(pl);
    if (mode == 1) fcs ^= 32'h00010000;
    for (int i = 0; i < n; i++) begin
      if (mode == 3 && i == 30) begin sb.push_back(8'h9C); sc.push_back(1'b1); end
      else begin sb.push_back(pl[i]); sc.push_back(1'b0); end
    end
    for (int j = 0; j < 4; j++) begin sb.push_back(fcs[8*j +: 8]); sc.push_back(1'b0); end
    sb.push_back(mode == 2 ? 8'hFE : 8'hFD); sc.push_back(1'b1);
    while (sb.size() % 8 != 0) begin sb.push_back(8'h07); sc.push_back(1'b1); end
    for (int w = 0; w < sb.size() / 8; w++) begin
      logic [63:0] d;
      logic [7:0]  c;
      for (int l = 0; l < 8; l++) begin d[8*l +: 8] = sb[8*w+l]; c[l] = sc[8*w+l]; end
      push_word(d, c, t);
    end
    idle(gap);
  endtask

  task automatic close_frame(int k, logic [7:0] code, string t);
    int npay, slot;
    logic [7:0] pay[$];
    logic [31:0] got;
    bit ok;
    npay = (fb.size() > 4) ? fb.size() - 4 : 0;
    for (int i = 0; i < npay; i++) begin
      exp_v[fp[i]/8][fp[i]%8] = 1'b1;
      exp_d[fp[i]/8][8*(fp[i]%8) +: 8] = fb[i];
      pay.push_back(fb[i]);
    end
    ok = (code == 8'hFD) && (fb.size() >= 64);
    if (fb.size() >= 4) begin
      got = {fb[npay+3], fb[npay+2], fb[npay+1], fb[npay]};
      if (got != crc32(pay)) ok = 0;
    end else ok = 0;
    slot = (npay > 0) ? fp[npay-1]/8 + 1 : k;
    exp_g[slot] = ok; exp_b[slot] = !ok; ft[slot] = t;
  endtask

  task automatic build_expect();
    int nw = wd.size();
    bit hunt = 1;
    exp_v = new[nw+2]; exp_d = new[nw+2]; exp_g = new[nw+2]; exp_b = new[nw+2]; ft = new[nw+2];
    for (int s = 0; s < nw + 2; s++) begin
      exp_v[s] = 0; exp_d[s] = 0; exp_g[s] = 0; exp_b[s] = 0; ft[s] = "R11";
    end
    for (int k = 0; k < nw; k++) begin
      if (hunt) begin
        if (wc[k] == 8'h01 && wd[k] == START_W) begin hunt = 0; fb.delete(); fp.delete(); end
      end else begin
        for (int l = 0; l < 8; l++) begin
          if (wc[k][l]) begin close_frame(k, wd[k][8*l +: 8], wt[k]); hunt = 1; break; end
          fb.push_back(wd[k][8*l +: 8]); fp.push_back(8*k + l);
        end
      end
    end
  endtask

  task automatic check_slot(int s);
    string t = (s < wt.size()) ? wt[s] : "R2";
    nchk++;
    if (rx_valid !== exp_v[s]) begin
      nfail++; $display("FAIL %s slot %0d valid actual=%h expected=%h", t, s, rx_valid, exp_v[s]);
    end
    if (exp_v[s] != 0) begin
      nchk++;
      for (int l = 0; l < 8; l++)
        if (exp_v[s][l] && rx_data[8*l +: 8] !== exp_d[s][8*l +: 8]) begin
          nfail++; $display("FAIL R4 slot %0d lane %0d data actual=%h expected=%h", s, l,
                            rx_data[8*l +: 8], exp_d[s][8*l +: 8]);
        end
    end
    nchk++;
    if (rx_good !== exp_g[s]) begin
      nfail++; $display("FAIL %s slot %0d good actual=%b expected=%b", ft[s], s, rx_good, exp_g[s]);
    end
    nchk++;
    if (rx_bad !== exp_b[s]) begin
      nfail++; $display("FAIL %s slot %0d bad actual=%b expected=%b", ft[s], s, rx_bad, exp_b[s]);
    end
  endtask

  initial begin
    #(20.0 * 200000);
    if (!done) begin
      nfail++;
      $display("FAIL R11 watchdog actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end

  initial begin
    rst_ni = 1'b0; xd = IDLE_W; xc = 8'hFF;
    idle(4);
    for (int n = 60; n < 68; n++) add_frame(n, 0, "R5", 2);
    add_frame(100, 0, "R6", 3);
    add_frame(70, 1, "R7", 2);
    add_frame(64, 2, "R8", 2);
    add_frame(80, 3, "R9", 2);
    add_frame(20, 0, "R10", 2);
    push_word({32'h555555FB, 32'h07070707}, 8'h1F, "R3");
    push_word(64'h11112222_D5555555, 8'h00, "R3");
    push_word(64'h0123456789ABCDEF, 8'h00, "R3");
    push_word(64'h07070707_070707FD, 8'hFF, "R3");
    idle(2);
    add_frame(61, 0, "R12", 0);
    add_frame(65, 0, "R12", 0);
    add_frame(66, 0, "R6", 3);
    build_expect();

    repeat (3) @(negedge clk);
    nchk++;  // R1 reset state
    if (rx_valid !== 8'h00 || rx_good !== 1'b0 || rx_bad !== 1'b0 || rx_data !== 64'h0) begin
      nfail++; $display("FAIL R1 reset actual=%h/%h/%b/%b expected=0/0/0/0", rx_data, rx_valid, rx_good, rx_bad);
    end
    rst_ni = 1'b1;
    for (int i = 0; i < wd.size() + 4; i++) begin
      @(negedge clk);
      if (i >= 2) check_slot(i - 2);
      if (i < wd.size()) begin xd = wd[i]; xc = wc[i]; end
      else begin xd = IDLE_W; xc = 8'hFF; end
    end
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule